// File: doc/BRIEF.md
# Paged SPI Register Slave

This block is an SPI target that lets a host controller read and write a bank of 16-bit control words. The words are grouped in three pages of 64 locations. Every chip-select frame carries a 16-bit command word and then one 16-bit data word, each most significant bit first. The command word holds a direction flag and a packed page/offset address. In a write frame the data word goes from the host into the addressed location. In a read frame the block returns the addressed word on MISO during the second half of the frame.

Most locations are plain storage. Five locations in page 0 are read-only and show live measurement values taken from an input bus. One location in page 1 is a soft-reset trigger: writing a fixed key value to it returns every storage location to its power-on value of zero. The SPI pins are sampled with the block's system clock, so SCLK must be several times slower than `clk`.

Top module: `spi_paged_regs`

## Requirements
- R1: Command word layout: bit 15 is 1 for a read and 0 for a write. Bits 12:11 give the page and bits 10:5 give the offset, so the location index is page*64+offset. Bits 14:13 and 4:0 are ignored. The host sends MSB first and the block samples MOSI on SCLK rising edges.
- R2: In a write frame, the 16 bits after the command are stored at the addressed location once the 32nd rising edge is seen. A later read of that location returns them.
- R3: In a read frame, MISO carries the addressed word MSB first. MISO changes only after SCLK falling edges, and the first data bit is valid before the 17th rising edge.
- R4: MISO is 0 while chip select is high and during the 16 command bits of every frame.
- R5: Page 3 (index 192 to 255) is invalid. A read there returns 0, and a write there changes no location.
- R6: Page 0 offsets 5, 6, 7, 9 and 10 read slots 0 to 4 of `meas_in`, in that order. Slot k is `meas_in[16*k+15:16*k]`. Writes to these offsets are ignored.
- R7: Writing 0xBB00 to page 1 offset 4 (index 68) clears every storage location to 0. Index 68 always reads 0.
- R8: Writing any other value to index 68 has no effect on any location.
- R9: If chip select rises before the 32nd rising edge of a write frame, the write is discarded. Rising edges after the 32nd in a frame are ignored.
- R10: While `rst_n` is low, all storage is cleared and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when idle |
| meas_in | input | 80 | Five 16-bit measurement slots, slot 0 in the low bits |

## Verification
The case hardest to reach from the pins is a write frame cut short. Chip select must rise after the command and part of the data have already been shifted in, with no strobe leaking into storage. The bench drives frames bit by bit with its own SCLK task. It can stop a write frame after 20 or 31 bits and then read the location back. The soft reset also needs a lead-up: storage is first filled with known non-zero patterns, a non-key value is written to index 68 to show that nothing moves, and only then is the key written and the whole pattern read back as zero.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_LSB  = 5;
  localparam int PAGE_W    = 2;
  localparam int OFF_W     = 6;
  localparam int ADDR_W    = PAGE_W + OFF_W;
  localparam int NUM_PAGES = 3;
  localparam int NUM_REGS  = NUM_PAGES << OFF_W;
  localparam int RST_ADDR  = (1 << OFF_W) + 4;
  localparam logic [WORD_W-1:0] RST_KEY = 16'hBB00;
  localparam int MEAS_CNT  = 5;

  typedef struct packed {
    logic       hit;
    logic [2:0] slot;
  } meas_sel_t;

  // Page 0 measurement locations and their input slot
  function automatic meas_sel_t meas_lookup(input logic [ADDR_W-1:0] a);
    meas_sel_t s;
    s.hit  = 1'b1;
    s.slot = 3'd0;
    case (a)
      8'd5:    s.slot = 3'd0;
      8'd6:    s.slot = 3'd1;
      8'd7:    s.slot = 3'd2;
      8'd9:    s.slot = 3'd3;
      8'd10:   s.slot = 3'd4;
      default: s.hit  = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic addr_valid(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(NUM_REGS);
  endfunction
endpackage

// File: rtl/spi_pg_shifter.sv
module spi_pg_shifter
  import spi_pg_pkg::*;
#(
  parameter int DW   = WORD_W,
  parameter int AW   = ADDR_W,
  parameter int ALSB = ADDR_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          miso
);
  localparam int CNT_W = $clog2(2*DW+1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(DW-1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(DW);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(2*DW-1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(2*DW);

  logic [2:0] sclk_sy;
  logic [1:0] cs_sy, mosi_sy;
  logic sclk_s, sclk_p, cs_s, mosi_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      cs_sy   <= {cs_sy[0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  assign sclk_s = sclk_sy[1];
  assign sclk_p = sclk_sy[2];
  assign cs_s   = cs_sy[1];
  assign mosi_s = mosi_sy[1];
  assign rise   = sclk_s & ~sclk_p;
  assign fall   = ~sclk_s & sclk_p;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    sh_q, sh_d, sh_next;
  logic             rd_q, rd_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    out_q, out_d;
  logic             miso_q, miso_d;
  logic             load_q, load_d;
  logic             wr_stb_q, wr_stb_d;
  logic [DW-1:0]    wr_data_q, wr_data_d;

  assign sh_next = {sh_q[DW-2:0], mosi_s};

  always_comb begin
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    rd_d      = rd_q;
    addr_d    = addr_q;
    out_d     = out_q;
    miso_d    = miso_q;
    load_d    = 1'b0;
    wr_stb_d  = 1'b0;
    wr_data_d = wr_data_q;
    if (cs_s) begin
      cnt_d  = '0;
      miso_d = 1'b0;
    end else begin
      if (rise && cnt_q != FRAME_END) begin
        sh_d  = sh_next;
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CMD_LAST) begin
          rd_d   = sh_next[DW-1];
          addr_d = sh_next[ALSB +: AW];
          load_d = 1'b1;
        end
        if (cnt_q == FRAME_LAST && !rd_q) begin
          wr_stb_d  = 1'b1;
          wr_data_d = sh_next;
        end
      end
      if (load_q) begin
        out_d = rd_q ? rd_data : '0;
      end else if (fall && cnt_q >= DATA_FIRST) begin
        miso_d = out_q[DW-1];
        out_d  = {out_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      out_q     <= '0;
      miso_q    <= 1'b0;
      load_q    <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      rd_q      <= rd_d;
      addr_q    <= addr_d;
      out_q     <= out_d;
      miso_q    <= miso_d;
      load_q    <= load_d;
      wr_stb_q  <= wr_stb_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign addr    = addr_q;
  assign wr_stb  = wr_stb_q;
  assign wr_data = wr_data_q;
  assign miso    = miso_q;

  p_miso_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (miso_q == 1'b0));

  p_miso_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_q != $past(miso_q)) |-> $past(fall || cs_s));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FRAME_END);

  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_q |=> !wr_stb_q);
endmodule

// File: rtl/spi_pg_regbank.sv
module spi_pg_regbank
  import spi_pg_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int AW    = ADDR_W,
  parameter int NREG  = NUM_REGS,
  parameter int NMEAS = MEAS_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_stb,
  input  logic [DW-1:0]    wr_data,
  input  logic [NMEAS*DW-1:0] meas_in,
  output logic [DW-1:0]    rd_data
);
  localparam logic [AW-1:0] RST_IDX = AW'(RST_ADDR);

  meas_sel_t sel;
  logic      valid, is_rst, wr_ok, soft_rst;
  logic [NREG-1:0][DW-1:0] regs;

  assign sel      = meas_lookup(addr);
  assign valid    = addr_valid(addr);
  assign is_rst   = (addr == RST_IDX);
  assign wr_ok    = wr_stb && valid && !sel.hit && !is_rst;
  assign soft_rst = wr_stb && is_rst && (wr_data == RST_KEY);

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    localparam meas_sel_t CSEL = meas_lookup(AW'(i));
    if (i == RST_ADDR || CSEL.hit) begin : g_none
      assign regs[i] = '0;
    end else begin : g_store
      logic [DW-1:0] cell_q, cell_d;
      logic          cell_en;
      always_comb begin
        cell_en = soft_rst || (wr_ok && addr == AW'(i));
        cell_d  = soft_rst ? '0 : wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= '0;
        else if (cell_en) cell_q <= cell_d;
      end
      assign regs[i] = cell_q;
    end
  end

  always_comb begin
    if (sel.hit)    rd_data = meas_in[sel.slot*DW +: DW];
    else if (valid) rd_data = regs[addr];
    else            rd_data = '0;
  end

  p_soft_rst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs[0] == '0 && regs[NREG-1] == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (regs[$past(addr)] == $past(wr_data)));
endmodule

// File: rtl/spi_paged_regs.sv
module spi_paged_regs
  import spi_pg_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int NMEAS = MEAS_CNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic [NMEAS*DW-1:0] meas_in
);
  logic [ADDR_W-1:0] addr;
  logic              wr_stb;
  logic [DW-1:0]     wr_data, rd_data;

  spi_pg_shifter #(.DW(DW), .AW(ADDR_W), .ALSB(ADDR_LSB)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .rd_data (rd_data),
    .addr    (addr),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .miso    (spi_miso)
  );

  spi_pg_regbank #(.DW(DW), .AW(ADDR_W), .NREG(NUM_REGS), .NMEAS(NMEAS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .meas_in (meas_in),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tb_spi_paged_regs.sv
`timescale 1ns/1ps
module tb_spi_paged_regs;
  localparam int HB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [79:0] meas_in;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] model [256];
  int idle_cnt = 0;

  always #2 clk = ~clk;

  spi_paged_regs dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .meas_in(meas_in)
  );

  function automatic logic [15:0] meas_val(input int k);
    return 16'hC0D0 + 16'(k * 16'h0111);
  endfunction

  function automatic int meas_slot(input int a);
    case (a)
      5: return 0; 6: return 1; 7: return 2; 9: return 3; 10: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] c, input logic [15:0] d, input int nbits,
                       output logic [15:0] rx);
    logic [31:0] tx;
    tx = {c, d};
    rx = '0;
    cs_n = 1'b0;
    wait_clk(HB);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[31-i];
      wait_clk(HB);
      if (i < 16) chk({15'd0, miso}, 16'd0, "R4 command-phase MISO");
      else        rx[31-i] = miso;
      sclk = 1'b1;
      wait_clk(HB);
      sclk = 1'b0;
    end
    wait_clk(HB);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(3*HB);
  endtask

  function automatic logic [15:0] cmd_of(input bit rd, input int a);
    return {rd, 2'b00, 2'(a >> 6), 6'(a), 5'd0};
  endfunction

  task automatic do_write(input int a, input logic [15:0] d);
    logic [15:0] rx;
    frame(cmd_of(1'b0, a), d, 32, rx);
    if (a == 68) begin
      if (d == 16'hBB00) for (int j = 0; j < 256; j++) model[j] = '0;
    end else if (a < 192 && meas_slot(a) < 0) begin
      model[a] = d;
    end
  endtask

  task automatic do_read(input int a, input string tag);
    logic [15:0] rx, exp;
    frame(cmd_of(1'b1, a), 16'h0000, 32, rx);
    if (meas_slot(a) >= 0)      exp = meas_val(meas_slot(a));
    else if (a >= 192 || a == 68) exp = '0;
    else                        exp = model[a];
    chk(rx, exp, $sformatf("%s read idx %0d", tag, a));
  endtask

  // Per-clock idle check of MISO (R4)
  always @(negedge clk) begin
    if (rst_n && cs_n) idle_cnt <= idle_cnt + 1;
    else               idle_cnt <= 0;
    if (rst_n && cs_n && idle_cnt >= 6 && !finished)
      chk({15'd0, miso}, 16'd0, "R4 idle MISO");
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx, lfsr;
    for (int k = 0; k < 5; k++) meas_in[16*k +: 16] = meas_val(k);
    for (int j = 0; j < 256; j++) model[j] = '0;
    wait_clk(5);
    chk({15'd0, miso}, 16'd0, "R10 MISO in reset");
    rst_n = 1'b1;
    wait_clk(10);

    // R10: storage reads zero after reset
    do_read(0, "R10");
    do_read(100, "R10");
    do_read(191, "R10");

    // R1 R2 R3: writes across all pages, varied patterns
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      int a;
      a = (n * 37 + 3) % 192;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_write(a, lfsr);
    end
    do_write(0, 16'hFFFF);
    do_write(191, 16'h8001);
    do_write(64, 16'h5A5A);
    do_write(128, 16'hA5A5);
    for (int n = 0; n < 24; n++) do_read((n * 37 + 3) % 192, "R2 R3");
    do_read(0, "R3 all-ones");
    do_read(191, "R1 last index");
    do_read(64, "R1 page1");
    do_read(128, "R1 page2");

    // R1: ignored command bits 14:13 and 4:0
    frame(cmd_of(1'b1, 64) | 16'h601F, 16'h0000, 32, rx);
    chk(rx, model[64], "R1 ignored command bits");

    // R5: invalid page
    do_read(200, "R5");
    do_write(200, 16'h1234);
    do_write(255, 16'h4321);
    do_read(200, "R5");
    do_read(200 - 64, "R5 no alias");
    do_read(255 - 64, "R5 no alias");
    do_read(255 - 192, "R5 no alias");

    // R6: measurement slots, writes ignored
    foreach (meas_in[k]) ;
    do_read(5, "R6"); do_read(6, "R6"); do_read(7, "R6");
    do_read(9, "R6"); do_read(10, "R6");
    do_write(7, 16'h0BAD);
    do_write(10, 16'h0BAD);
    do_read(7, "R6 write ignored");
    do_read(10, "R6 write ignored");
    do_write(8, 16'h3C3C);
    do_read(8, "R6 neighbour stored");

    // R9: truncated write frames discarded
    frame(cmd_of(1'b0, 0), 16'h1357, 20, rx);
    do_read(0, "R9 truncated 20");
    frame(cmd_of(1'b0, 0), 16'h1357, 31, rx);
    do_read(0, "R9 truncated 31");

    // R8: non-key value to reset location
    do_write(68, 16'hBB01);
    do_write(68, 16'h00BB);
    do_read(0, "R8"); do_read(64, "R8"); do_read(191, "R8"); do_read(8, "R8");
    do_read(68, "R7 reset loc reads zero");

    // R7: key clears all storage
    do_write(68, 16'hBB00);
    do_read(0, "R7"); do_read(8, "R7"); do_read(64, "R7");
    do_read(128, "R7"); do_read(191, "R7"); do_read(6, "R7 meas kept");
    for (int n = 0; n < 24; n += 5) do_read((n * 37 + 3) % 192, "R7");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule